// File: doc/BRIEF.md
# Pixel lookup address conditioner

This block sits in front of a colour lookup table. Each pixel clock it takes an 8-bit plane value and a 2-bit overlay code. It conditions both, and in the next cycle it tells the downstream lookup where the colour comes from. The source is either the palette RAM at a conditioned plane address or one of four overlay colour registers.

Conditioning works in four ways. A read mask removes plane bits. A blink mask zeroes chosen plane bits during the dark part of a blink cycle. Each overlay bit can be disabled. Each overlay bit can also be made to blink. The blink cycle is timed in frames: an internal counter steps on every rising edge of the vertical-sync input.

A small CPU port writes and reads back three 8-bit registers: control, plane read mask and plane blink mask.

Top module: `pix_lookup_prep`

## Requirements
- R1: The CPU port selects a register with `cpu_addr`: 0 is control, 1 is the plane read mask, 2 is the plane blink mask, and 3 reads as zero. A write is taken on a clock edge with `cpu_we` high. `cpu_rdata` shows the selected register one clock after the address, with register bit 0 on data bit 0.
- R2: While `rst` is high, the control register and the frame counter clear, and the outputs `out_addr`, `out_ovl` and `out_ram` go to 0. The mask registers are not cleared.
- R3: `out_addr` is the registered pixel ANDed bitwise with the read mask. A mask bit of 1 keeps that plane.
- R4: Control bits [5:4] pick the blink cycle, counted in rising edges of `vsync`. Code 00 gives 16 lit and 48 dark. Code 01 gives 16 lit and 16 dark. Codes 10 and 11 give 32 lit and 32 dark. The counter starts lit after reset, wraps at the end of the cycle, and changes only on a `vsync` rising edge.
- R5: In the dark phase, every plane whose blink-mask bit is 1 is forced to 0 in `out_addr`. Planes whose blink-mask bit is 0, and all planes in the lit phase, pass unchanged.
- R6: Control bit 0 enables overlay bit 0, and control bit 1 enables overlay bit 1. A disabled overlay bit reads as 0.
- R7: Control bit 3 makes overlay bit 0 blink, and control bit 2 makes overlay bit 1 blink. A blinking bit is 0 in the dark phase and passes in the lit phase. Blinking only matters for a bit that is also enabled.
- R8: If the conditioned overlay code is nonzero, then `out_ram` is 0 and `out_ovl` equals that code. If the code is zero, `out_ovl` is 0 and `out_ram` equals control bit 6: 1 selects the palette RAM, 0 selects overlay register 0.
- R9: The outputs reflect the inputs one clock after they are sampled. A register written on one edge already applies to a pixel sampled on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 8 | Plane value of the incoming pixel |
| ovl_in | input | 2 | Overlay code of the incoming pixel |
| vsync | input | 1 | Vertical sync; the blink counter steps on its rising edge |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register select |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Registered read data |
| out_addr | output | 8 | Conditioned palette address |
| out_ovl | output | 2 | Overlay register index when `out_ram` is 0 |
| out_ram | output | 1 | 1: colour from palette RAM at `out_addr` |

## Verification
The assertions check these rules on every cycle:
- the read mask and, in the dark phase, the blink mask never let a removed plane through;
- a disabled overlay bit stays zero;
- the RAM and overlay choices never conflict;
- the frame counter moves only on a sync edge and is clear after reset.

The exact lengths of each blink pattern, the wrap points, and the crossed assignment of the overlay blink bits can only be shown by the bench's scenarios. The bench steps `vsync` through full cycles of every rate code and checks a pixel after each step. Those scenarios also cover read-back and the rule that a register applies to the very next pixel.

// File: rtl/pix_lookup_pkg.sv
package pix_lookup_pkg;

  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] SEL_CTRL  = 2'd0;
  localparam logic [REG_AW-1:0] SEL_RMASK = 2'd1;
  localparam logic [REG_AW-1:0] SEL_BMASK = 2'd2;

  // Control register layout; bit positions are fixed by the CPU view.
  typedef struct packed {
    logic       spare;      // [7] stored only
    logic       ram_src;    // [6]
    logic [1:0] rate;       // [5:4]
    logic       ov0_blink;  // [3]
    logic       ov1_blink;  // [2]
    logic       ov1_en;     // [1]
    logic       ov0_en;     // [0]
  } ctrl_t;

endpackage

// File: rtl/pix_lookup_regs.sv
module pix_lookup_regs
  import pix_lookup_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output ctrl_t             ctrl,
  output logic [DW-1:0]     rmask,
  output logic [DW-1:0]     bmask
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (we && addr == SEL_CTRL) begin
      ctrl <= ctrl_t'(wdata);
    end
  end

  // Mask registers carry no reset, so they map onto plain fabric registers.
  always_ff @(posedge clk) begin
    if (we && addr == SEL_RMASK) rmask <= wdata;
    if (we && addr == SEL_BMASK) bmask <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        SEL_CTRL:  rdata <= DW'(ctrl);
        SEL_RMASK: rdata <= rmask;
        SEL_BMASK: rdata <= bmask;
        default:   rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/pix_lookup_blink.sv
module pix_lookup_blink #(
  parameter int LIT_SHORT  = 16,
  parameter int DARK_SHORT = 16,
  parameter int DARK_LONG  = 48,
  parameter int LIT_LONG   = 32,
  parameter int DARK_MID   = 32,
  localparam int TOT_A = LIT_SHORT + DARK_LONG,
  localparam int TOT_B = LIT_SHORT + DARK_SHORT,
  localparam int TOT_C = LIT_LONG + DARK_MID,
  localparam int TOT_AB = (TOT_A > TOT_B) ? TOT_A : TOT_B,
  localparam int TOT_MAX = (TOT_AB > TOT_C) ? TOT_AB : TOT_C,
  localparam int CW = $clog2(TOT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vsync,
  input  logic [1:0]    rate,
  output logic [CW-1:0] cnt,
  output logic          step,
  output logic          dark
);

  logic          vsync_q;
  logic [CW-1:0] lit_len;
  logic [CW-1:0] last;

  always_comb begin
    case (rate)
      2'b00: begin
        lit_len = CW'(LIT_SHORT);
        last    = CW'(TOT_A - 1);
      end
      2'b01: begin
        lit_len = CW'(LIT_SHORT);
        last    = CW'(TOT_B - 1);
      end
      default: begin
        lit_len = CW'(LIT_LONG);
        last    = CW'(TOT_C - 1);
      end
    endcase
  end

  assign step = vsync & ~vsync_q;
  assign dark = (cnt >= lit_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      vsync_q <= 1'b0;
      cnt     <= '0;
    end else begin
      vsync_q <= vsync;
      if (step) cnt <= (cnt >= last) ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pix_lookup_path.sv
module pix_lookup_path
  import pix_lookup_pkg::*;
#(
  parameter int PW = 8,
  parameter int OW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] pix_in,
  input  logic [OW-1:0] ovl_in,
  input  ctrl_t         ctrl,
  input  logic [PW-1:0] rmask,
  input  logic [PW-1:0] bmask,
  input  logic          dark,
  output logic [PW-1:0] out_addr,
  output logic [OW-1:0] out_ovl,
  output logic          out_ram
);

  logic [OW-1:0] ov_en;
  logic [OW-1:0] ov_blk;
  logic [OW-1:0] ov_c;
  logic [PW-1:0] plane_c;

  assign ov_en  = {ctrl.ov1_en, ctrl.ov0_en};
  assign ov_blk = {ctrl.ov1_blink, ctrl.ov0_blink};

  for (genvar i = 0; i < OW; i++) begin : g_ovl
    assign ov_c[i] = ovl_in[i] & ov_en[i] & ~(ov_blk[i] & dark);
  end

  assign plane_c = pix_in & rmask & ~(bmask & {PW{dark}});

  always_ff @(posedge clk) begin
    if (rst) begin
      out_addr <= '0;
      out_ovl  <= '0;
      out_ram  <= 1'b0;
    end else begin
      out_addr <= plane_c;
      out_ovl  <= ov_c;
      out_ram  <= (ov_c == '0) & ctrl.ram_src;
    end
  end

endmodule

// File: rtl/pix_lookup_prep.sv
module pix_lookup_prep
  import pix_lookup_pkg::*;
#(
  parameter int PW = 8,
  parameter int OW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PW-1:0]     pix_in,
  input  logic [OW-1:0]     ovl_in,
  input  logic              vsync,
  input  logic              cpu_we,
  input  logic [REG_AW-1:0] cpu_addr,
  input  logic [PW-1:0]     cpu_wdata,
  output logic [PW-1:0]     cpu_rdata,
  output logic [PW-1:0]     out_addr,
  output logic [OW-1:0]     out_ovl,
  output logic              out_ram
);

  ctrl_t         ctrl;
  logic [PW-1:0] rmask;
  logic [PW-1:0] bmask;
  logic [5:0]    blink_cnt;
  logic          blink_step;
  logic          blink_dark;

  pix_lookup_regs #(.DW(PW)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (cpu_we),
    .addr  (cpu_addr),
    .wdata (cpu_wdata),
    .rdata (cpu_rdata),
    .ctrl  (ctrl),
    .rmask (rmask),
    .bmask (bmask)
  );

  pix_lookup_blink u_blink (
    .clk   (clk),
    .rst   (rst),
    .vsync (vsync),
    .rate  (ctrl.rate),
    .cnt   (blink_cnt[5:0]),
    .step  (blink_step),
    .dark  (blink_dark)
  );

  pix_lookup_path #(.PW(PW), .OW(OW)) u_path (
    .clk      (clk),
    .rst      (rst),
    .pix_in   (pix_in),
    .ovl_in   (ovl_in),
    .ctrl     (ctrl),
    .rmask    (rmask),
    .bmask    (bmask),
    .dark     (blink_dark),
    .out_addr (out_addr),
    .out_ovl  (out_ovl),
    .out_ram  (out_ram)
  );

endmodule

// File: rtl/pix_lookup_prep_chk.sv
module pix_lookup_prep_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] out_addr,
  input logic [1:0] out_ovl,
  input logic       out_ram,
  input logic [7:0] ctrl,
  input logic [7:0] rmask,
  input logic [7:0] bmask,
  input logic [5:0] cnt,
  input logic       step,
  input logic       dark
);

  // R2
  after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt == 6'd0 && out_addr == 8'd0 && out_ovl == 2'd0 && !out_ram));

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt));

  // R3
  rmask_chk: assert property (@(posedge clk) disable iff (rst)
    (out_addr & ~$past(rmask)) == 8'd0);

  // R5
  bmask_chk: assert property (@(posedge clk) disable iff (rst)
    $past(dark) |-> (out_addr & $past(bmask)) == 8'd0);

  // R6
  ov0_off_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl[0]) |-> !out_ovl[0]);

  // R6
  ov1_off_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl[1]) |-> !out_ovl[1]);

  // R8
  src_excl_chk: assert property (@(posedge clk) disable iff (rst)
    out_ram |-> out_ovl == 2'd0);

  // R8
  ram_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (out_ovl == 2'd0 && $past(ctrl[6])) |-> out_ram);

endmodule

bind pix_lookup_prep pix_lookup_prep_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .out_addr (out_addr),
  .out_ovl  (out_ovl),
  .out_ram  (out_ram),
  .ctrl     (8'(ctrl)),
  .rmask    (rmask),
  .bmask    (bmask),
  .cnt      (blink_cnt),
  .step     (blink_step),
  .dark     (blink_dark)
);

// File: tb/test_pix_lookup_prep.sv
module test_pix_lookup_prep;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] pix_in;
  logic [1:0] ovl_in;
  logic       vsync;
  logic       cpu_we;
  logic [1:0] cpu_addr;
  logic [7:0] cpu_wdata;
  logic [7:0] cpu_rdata;
  logic [7:0] out_addr;
  logic [1:0] out_ovl;
  logic       out_ram;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // Bench copies of the programmed state.
  logic [7:0] m_ctrl, m_rm, m_bm;
  int m_cnt;

  logic [10:0] exp_q[$];
  int          stamp_q[$];
  string       tag_q[$];

  pix_lookup_prep i_pix_lookup_prep (
    .clk(clk), .rst(rst), .pix_in(pix_in), .ovl_in(ovl_in), .vsync(vsync),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .out_addr(out_addr), .out_ovl(out_ovl),
    .out_ram(out_ram)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lit_len(input logic [1:0] r);
    return (r[1]) ? 32 : 16;
  endfunction

  function automatic int cycle_len(input logic [1:0] r);
    return (r == 2'b01) ? 32 : 64;
  endfunction

  function automatic logic [10:0] model(input logic [7:0] p, input logic [1:0] o);
    logic dark;
    logic [7:0] a;
    logic o0, o1;
    dark = (m_cnt >= lit_len(m_ctrl[5:4]));
    a  = p & m_rm & ~(m_bm & {8{dark}});
    o0 = o[0] & m_ctrl[0] & ~(m_ctrl[3] & dark);
    o1 = o[1] & m_ctrl[1] & ~(m_ctrl[2] & dark);
    if ({o1, o0} != 2'b00) return {a, o1, o0, 1'b0};
    return {a, 2'b00, m_ctrl[6]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: each result appears one clock after its pixel was sampled.
  always @(negedge clk) begin
    if (exp_q.size() > 0 && stamp_q[0] == cyc - 1) begin
      check(tag_q[0], {21'd0, out_addr, out_ovl, out_ram}, {21'd0, exp_q[0]});
      void'(exp_q.pop_front());
      void'(stamp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic drive_pix(input logic [7:0] p, input logic [1:0] o, input string tag);
    @(negedge clk);
    pix_in = p;
    ovl_in = o;
    exp_q.push_back(model(p, o));
    stamp_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
    case (a)
      2'd0: m_ctrl = d;
      2'd1: m_rm = d;
      2'd2: m_bm = d;
      default: ;
    endcase
  endtask

  task automatic read_reg(input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    cpu_addr = a;
    @(negedge clk);
    check("R1 readback", {24'd0, cpu_rdata}, {24'd0, exp});
  endtask

  task automatic vs_pulse();
    @(negedge clk);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
    m_cnt = (m_cnt >= cycle_len(m_ctrl[5:4]) - 1) ? 0 : m_cnt + 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; pix_in = 8'h00; ovl_in = 2'b00; vsync = 1'b0;
    cpu_we = 1'b0; cpu_addr = 2'd0; cpu_wdata = 8'h00;
    m_ctrl = 8'h00; m_rm = 8'h00; m_bm = 8'h00; m_cnt = 0;
    repeat (3) @(negedge clk);
    // R2: reset values
    check("R2 out_addr", {24'd0, out_addr}, 32'd0);
    check("R2 out_ovl", {30'd0, out_ovl}, 32'd0);
    check("R2 out_ram", {31'd0, out_ram}, 32'd0);
    rst = 1'b0;
    read_reg(2'd0, 8'h00);

    // R1: register access
    write_reg(2'd0, 8'h40);
    write_reg(2'd1, 8'hFF);
    write_reg(2'd2, 8'h00);
    read_reg(2'd0, 8'h40);
    read_reg(2'd1, 8'hFF);
    read_reg(2'd2, 8'h00);
    write_reg(2'd1, 8'h01);
    read_reg(2'd1, 8'h01);
    read_reg(2'd3, 8'h00);
    write_reg(2'd1, 8'hFF);

    // R3 / R9: read mask, back-to-back pixels
    drive_pix(8'hA5, 2'b00, "R3 full mask");
    drive_pix(8'h3C, 2'b00, "R9 next pixel");
    write_reg(2'd1, 8'h0F);
    drive_pix(8'hA5, 2'b00, "R3 low nibble");
    write_reg(2'd1, 8'hF0);
    drive_pix(8'hA5, 2'b00, "R9 mask applies at once");

    // R8: colour source with zero overlay
    write_reg(2'd0, 8'h00);
    drive_pix(8'h77, 2'b00, "R8 overlay reg 0");
    write_reg(2'd1, 8'hFF);

    // R6 / R8: overlay enables
    write_reg(2'd0, 8'h43);
    drive_pix(8'h11, 2'b10, "R8 overlay 2");
    drive_pix(8'h11, 2'b11, "R8 overlay 3");
    drive_pix(8'h11, 2'b01, "R8 overlay 1");
    write_reg(2'd0, 8'h41);
    drive_pix(8'h22, 2'b11, "R6 only ov0 enabled");
    drive_pix(8'h22, 2'b10, "R6 ov1 disabled");
    write_reg(2'd0, 8'h42);
    drive_pix(8'h22, 2'b01, "R6 ov0 disabled");

    // R4 / R5 / R7: sweep every rate code through a full cycle and more
    write_reg(2'd2, 8'hF0);
    for (int code = 0; code < 4; code++) begin
      write_reg(2'd0, 8'h4F | 8'(code << 4));
      for (int k = 0; k < 70; k++) begin
        vs_pulse();
        drive_pix(8'hFF, 2'b11, "R4 R5 R7 blink sweep");
      end
    end

    // R7: blink bits cross over; only one overlay bit blinking
    while (m_cnt < 16) vs_pulse();
    write_reg(2'd0, 8'h47);
    drive_pix(8'h0F, 2'b11, "R7 ov1 blink dark");
    write_reg(2'd0, 8'h4B);
    drive_pix(8'h0F, 2'b11, "R7 ov0 blink dark");
    write_reg(2'd0, 8'h4C);
    drive_pix(8'h0F, 2'b11, "R7 blink without enable");

    repeat (4) @(negedge clk);
    check("R9 queue drained", exp_q.size(), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule